// File: doc/BRIEF.md
# Ancillary Packet Inserter with Space Check

This block takes one ancillary data packet at a time from a host and places it into the blanking space of an outgoing 10-bit video word stream. The host fills the packet: three 8-bit header registers (data identifier, block number or secondary identifier, and data count) and a 256-word user-data RAM. Each is written through its own load strobe, and the RAM also takes a write address. The host then raises a ready input. The block takes the packet, drops its empty flag and waits for a blanking window large enough for the entire packet. The window can be horizontal blanking after the end-of-active-video marker, or the active part of a vertical blanking line after the start-of-active-video marker. When it finds one, it sends the packet and raises the empty flag again.

Line timing comes from an external timing generator. It supplies a one-cycle marker on the last word of each timing reference sequence, a vertical blanking flag, and the free room in words of the window that follows each marker. A packet is never split across lines. A packet that does not fit is held back until a later window can hold all of it. Words that do not belong to a packet pass through with one cycle of delay.

Top module: `anci_inserter`

## Requirements
- R1: On a clock where `ld_did_i`, `ld_dbn_i` or `ld_dc_i` is high and `empty_o` is high, the matching header register takes `data_i[7:0]`.
- R2: On a clock where `ld_udw_i` is high and `empty_o` is high, the user-data RAM stores `data_i[9:0]` at `udw_addr_i`.
- R3: `empty_o` is 1 after reset. It falls on the clock after `pkt_rdy_i` is seen high while empty, and rises on the same clock that the checksum word appears on `vid_o`.
- R4: A sent packet occupies DC+7 consecutive words on `vid_o` in this order: 000h, 3FFh, 3FFh, DID, DBN, DC, DC user words, checksum. Each header word carries the 8-bit register value in bits 7:0, the even parity of bits 7:0 in bit 8, and the complement of bit 8 in bit 9.
- R5: The checksum word holds, in bits 8:0, the 9-bit sum of bits 8:0 of every word from DID through the last user word. Bit 9 is the complement of bit 8.
- R6: If `gen_par_i` was high when the packet was taken, each user word is sent as RAM bits 7:0 with generated parity (bit 8 even parity of bits 7:0, bit 9 its complement). Otherwise the stored 10-bit word is sent unchanged.
- R7: With horizontal placement selected, a packet whose DC+7 is no larger than `h_room_i` starts two clocks after the cycle where `eav_xyz_i` is high. Its first word then stands where the word after the marker would have appeared. An exact fit is accepted.
- R8: If DC+7 exceeds the room of a window, nothing is inserted there: `vid_o` keeps passing the input and `empty_o` stays low until a later window fits.
- R9: With vertical placement selected, a packet is inserted after a cycle where `sav_xyz_i` and `vblank_i` are both high and DC+7 is no larger than `v_room_i`. A start-of-active-video marker with `vblank_i` low is never used.
- R10: While `empty_o` is low, all load strobes are ignored and the held packet is sent unchanged.
- R11: Outside a packet, `vid_o` equals `vid_i` delayed by one clock. It is 000h after reset.
- R12: A window whose kind (`use_h_i` or `use_v_i`, sampled when the packet is taken) was not selected is never used, whatever its room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_i | input | 10 | Incoming video words |
| eav_xyz_i | input | 1 | High on the last word of an end-of-active-video marker |
| sav_xyz_i | input | 1 | High on the last word of a start-of-active-video marker |
| vblank_i | input | 1 | Current line is in vertical blanking |
| h_room_i | input | 12 | Free words in the horizontal window after this marker |
| v_room_i | input | 12 | Free words in the vertical window after this marker |
| use_h_i | input | 1 | Allow horizontal placement (sampled on acceptance) |
| use_v_i | input | 1 | Allow vertical placement (sampled on acceptance) |
| gen_par_i | input | 1 | Generate user-word parity (sampled on acceptance) |
| pkt_rdy_i | input | 1 | Host has loaded a packet |
| data_i | input | 10 | Load data for headers and user RAM |
| ld_did_i | input | 1 | Load identifier register |
| ld_dbn_i | input | 1 | Load block number / secondary identifier register |
| ld_dc_i | input | 1 | Load data count register |
| ld_udw_i | input | 1 | Write user-data RAM |
| udw_addr_i | input | 8 | User-data RAM write address |
| vid_o | output | 10 | Outgoing video with packet inserted |
| empty_o | output | 1 | Ready for a new packet |

## Verification
The bench sends a packet whose total length exactly equals the room of the window. A space check that is off by one would defer this packet and leave the stream untouched. It then sends a packet one word longer than the room. An inserter that ignores the room would overwrite words past the end of blanking, and an inserter that drops a deferred packet would never send it on the next line. It sends a packet with a data count of zero and checks that the count is taken literally. It tries to overwrite the headers and a RAM word while a packet is pending, so a design that fails to lock the registers shows corrupted header, user or checksum words. Finally it offers windows of an unselected kind, and a start-of-active-video marker outside vertical blanking. A design that misdecodes either places the packet in the wrong spot.

// File: rtl/anci_pkg.sv
package anci_pkg;

    localparam int WORD_W   = 10;
    localparam int BYTE_W   = 8;
    localparam int OVERHEAD = 7;   // three flag words, three header words, checksum

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        PH_FLG0, PH_FLG1, PH_FLG2, PH_ID, PH_BLK, PH_CNT, PH_USER, PH_SUM
    } phase_e;

    typedef struct packed {
        byte_t did;
        byte_t dbn;
        byte_t dc;
    } hdr_t;

    typedef struct packed {
        logic use_h;
        logic use_v;
        logic gen_par;
    } mode_t;

    function automatic word_t with_parity(input byte_t b);
        logic p;
        p = ^b;
        return {~p, p, b};
    endfunction

endpackage

// File: rtl/anci_store.sv
module anci_store
    import anci_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_i,
    input  logic              gen_par_i,
    input  word_t             data_i,
    input  logic              ld_did_i,
    input  logic              ld_dbn_i,
    input  logic              ld_dc_i,
    input  logic              ld_udw_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output hdr_t              hdr_o,
    output word_t             udw_o
);
    localparam int DEPTH = 1 << ADDR_W;

    hdr_t  hdr_q;
    word_t mem [DEPTH];
    word_t raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q <= '0;
        end else if (open_i) begin
            if (ld_did_i) hdr_q.did <= data_i[BYTE_W-1:0];
            if (ld_dbn_i) hdr_q.dbn <= data_i[BYTE_W-1:0];
            if (ld_dc_i)  hdr_q.dc  <= data_i[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (open_i && ld_udw_i) mem[waddr_i] <= data_i;
    end

    assign raw   = mem[raddr_i];
    assign udw_o = gen_par_i ? with_parity(raw[BYTE_W-1:0]) : raw;
    assign hdr_o = hdr_q;

    AST_HDR_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (!open_i && (ld_did_i || ld_dbn_i || ld_dc_i)) |=> $stable(hdr_q)); // R10

endmodule

// File: rtl/anci_sched.sv
module anci_sched
    import anci_pkg::*;
#(
    parameter int ROOM_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_rdy_i,
    input  mode_t             mode_i,
    input  logic              eav_xyz_i,
    input  logic              sav_xyz_i,
    input  logic              vblank_i,
    input  logic [ROOM_W-1:0] h_room_i,
    input  logic [ROOM_W-1:0] v_room_i,
    input  byte_t             dc_i,
    input  logic              busy_i,
    input  logic              done_i,
    output logic              empty_o,
    output mode_t             mode_o,
    output logic              start_o
);
    logic              empty_q;
    mode_t             mode_q;
    logic [ROOM_W-1:0] need;
    logic              h_ok;
    logic              v_ok;

    assign need    = ROOM_W'(dc_i) + ROOM_W'(OVERHEAD);
    assign h_ok    = mode_q.use_h && eav_xyz_i && (need <= h_room_i);
    assign v_ok    = mode_q.use_v && sav_xyz_i && vblank_i && (need <= v_room_i);
    assign start_o = !empty_q && !busy_i && (h_ok || v_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= 1'b1;
            mode_q  <= '0;
        end else if (empty_q) begin
            if (pkt_rdy_i) begin
                empty_q <= 1'b0;
                mode_q  <= mode_i;
            end
        end else if (done_i) begin
            empty_q <= 1'b1;
        end
    end

    assign empty_o = empty_q;
    assign mode_o  = mode_q;

    AST_EMPTY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(empty_q) |-> $past(done_i)); // R3
    AST_BUSY_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> !empty_q); // R3
    AST_FITS_ROOM: assert property (@(posedge clk) disable iff (rst)
        start_o |-> ((need <= h_room_i) || (need <= v_room_i))); // R8

endmodule

// File: rtl/anci_emit.sv
module anci_emit
    import anci_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  hdr_t              hdr_i,
    input  word_t             udw_i,
    input  word_t             vid_i,
    output logic [ADDR_W-1:0] raddr_o,
    output logic              busy_o,
    output logic              done_o,
    output word_t             vid_o
);
    phase_e            phase_q;
    logic              busy_q;
    logic [ADDR_W-1:0] ucnt_q;
    logic [8:0]        chk_q;
    word_t             vid_q;
    word_t             word;
    logic              sums;
    logic [ADDR_W-1:0] last_addr;

    assign last_addr = ADDR_W'(hdr_i.dc - 8'd1);
    assign sums      = phase_q inside {PH_ID, PH_BLK, PH_CNT, PH_USER};

    always_comb begin
        unique case (phase_q)
            PH_FLG0:          word = '0;
            PH_FLG1, PH_FLG2: word = '1;
            PH_ID:            word = with_parity(hdr_i.did);
            PH_BLK:           word = with_parity(hdr_i.dbn);
            PH_CNT:           word = with_parity(hdr_i.dc);
            PH_USER:          word = udw_i;
            default:          word = {~chk_q[8], chk_q};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= PH_FLG0;
            ucnt_q  <= '0;
            chk_q   <= '0;
            vid_q   <= '0;
        end else begin
            vid_q <= busy_q ? word : vid_i;
            if (start_i) begin
                busy_q  <= 1'b1;
                phase_q <= PH_FLG0;
                ucnt_q  <= '0;
                chk_q   <= '0;
            end else if (busy_q) begin
                if (sums) chk_q <= chk_q + word[8:0];
                unique case (phase_q)
                    PH_FLG0: phase_q <= PH_FLG1;
                    PH_FLG1: phase_q <= PH_FLG2;
                    PH_FLG2: phase_q <= PH_ID;
                    PH_ID:   phase_q <= PH_BLK;
                    PH_BLK:  phase_q <= PH_CNT;
                    PH_CNT:  phase_q <= (hdr_i.dc == 8'd0) ? PH_SUM : PH_USER;
                    PH_USER: begin
                        if (ucnt_q == last_addr) phase_q <= PH_SUM;
                        else                     ucnt_q  <= ucnt_q + 1'b1;
                    end
                    default: busy_q <= 1'b0;
                endcase
            end
        end
    end

    assign raddr_o = ucnt_q;
    assign busy_o  = busy_q;
    assign done_o  = busy_q && (phase_q == PH_SUM);
    assign vid_o   = vid_q;

    AST_FLAG_LEAD: assert property (@(posedge clk) disable iff (rst)
        start_i |-> ##2 (vid_q == 10'h000)); // R4
    AST_SUM_BIT9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (vid_q[9] == ~vid_q[8])); // R5
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !start_i); // R3

endmodule

// File: rtl/anci_inserter.sv
module anci_inserter
    import anci_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ROOM_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [9:0]        vid_i,
    input  logic              eav_xyz_i,
    input  logic              sav_xyz_i,
    input  logic              vblank_i,
    input  logic [ROOM_W-1:0] h_room_i,
    input  logic [ROOM_W-1:0] v_room_i,
    input  logic              use_h_i,
    input  logic              use_v_i,
    input  logic              gen_par_i,
    input  logic              pkt_rdy_i,
    input  logic [9:0]        data_i,
    input  logic              ld_did_i,
    input  logic              ld_dbn_i,
    input  logic              ld_dc_i,
    input  logic              ld_udw_i,
    input  logic [ADDR_W-1:0] udw_addr_i,
    output logic [9:0]        vid_o,
    output logic              empty_o
);
    hdr_t              hdr;
    word_t             udw;
    mode_t             mode_in;
    mode_t             mode;
    logic [ADDR_W-1:0] raddr;
    logic              start;
    logic              busy;
    logic              done;
    logic              empty;

    assign mode_in = '{use_h: use_h_i, use_v: use_v_i, gen_par: gen_par_i};

    anci_store #(.ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .open_i    (empty),
        .gen_par_i (mode.gen_par),
        .data_i    (data_i),
        .ld_did_i  (ld_did_i),
        .ld_dbn_i  (ld_dbn_i),
        .ld_dc_i   (ld_dc_i),
        .ld_udw_i  (ld_udw_i),
        .waddr_i   (udw_addr_i),
        .raddr_i   (raddr),
        .hdr_o     (hdr),
        .udw_o     (udw)
    );

    anci_sched #(.ROOM_W(ROOM_W)) u_sched (
        .clk       (clk),
        .rst       (rst),
        .pkt_rdy_i (pkt_rdy_i),
        .mode_i    (mode_in),
        .eav_xyz_i (eav_xyz_i),
        .sav_xyz_i (sav_xyz_i),
        .vblank_i  (vblank_i),
        .h_room_i  (h_room_i),
        .v_room_i  (v_room_i),
        .dc_i      (hdr.dc),
        .busy_i    (busy),
        .done_i    (done),
        .empty_o   (empty),
        .mode_o    (mode),
        .start_o   (start)
    );

    anci_emit #(.ADDR_W(ADDR_W)) u_emit (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .hdr_i   (hdr),
        .udw_i   (udw),
        .vid_i   (vid_i),
        .raddr_o (raddr),
        .busy_o  (busy),
        .done_o  (done),
        .vid_o   (vid_o)
    );

    assign empty_o = empty;

endmodule

// File: tb/tb_anci_inserter.sv
`timescale 1ns/1ps
module tb_anci_inserter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  vid_i = '0;
    logic        eav_xyz_i = 0, sav_xyz_i = 0, vblank_i = 0;
    logic [11:0] h_room_i = '0, v_room_i = '0;
    logic        use_h_i = 0, use_v_i = 0, gen_par_i = 0, pkt_rdy_i = 0;
    logic [9:0]  data_i = '0;
    logic        ld_did_i = 0, ld_dbn_i = 0, ld_dc_i = 0, ld_udw_i = 0;
    logic [7:0]  udw_addr_i = '0;
    logic [9:0]  vid_o;
    logic        empty_o;

    int checks = 0;
    int fails  = 0;
    bit over   = 0;

    logic [9:0] ram_m [256];
    logic [9:0] exp_w [264];
    int         exp_len;

    localparam logic [9:0] HOLD = 10'h155;

    always #2 clk = ~clk;

    anci_inserter dut (.*);

    function automatic logic [9:0] p10(input logic [7:0] b);
        return {~(^b), ^b, b};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic build(input logic [7:0] did, input logic [7:0] dbn, input logic [7:0] dc, input bit par);
        logic [8:0] s;
        exp_w[0] = 10'h000; exp_w[1] = 10'h3FF; exp_w[2] = 10'h3FF;
        exp_w[3] = p10(did); exp_w[4] = p10(dbn); exp_w[5] = p10(dc);
        for (int k = 0; k < int'(dc); k++)
            exp_w[6+k] = par ? p10(ram_m[k][7:0]) : ram_m[k];
        s = '0;
        for (int k = 3; k < 6 + int'(dc); k++) s = s + exp_w[k][8:0];
        exp_w[6+int'(dc)] = {~s[8], s};
        exp_len = int'(dc) + 7;
    endtask

    task automatic load_hdr(input logic [7:0] did, input logic [7:0] dbn, input logic [7:0] dc);
        @(negedge clk); data_i = {2'b00, did}; ld_did_i = 1;
        @(negedge clk); ld_did_i = 0; data_i = {2'b11, dbn}; ld_dbn_i = 1;
        @(negedge clk); ld_dbn_i = 0; data_i = {2'b01, dc}; ld_dc_i = 1;
        @(negedge clk); ld_dc_i = 0;
    endtask

    task automatic load_ram();
        for (int j = 0; j < 256; j++) begin
            @(negedge clk);
            udw_addr_i = 8'(j);
            data_i     = 10'((j * 73 + 449) % 1024);
            ram_m[j]   = data_i;
            ld_udw_i   = 1;
        end
        @(negedge clk); ld_udw_i = 0;
    endtask

    task automatic arm(input bit h, input bit v, input bit par);
        @(negedge clk); use_h_i = h; use_v_i = v; gen_par_i = par; pkt_rdy_i = 1;
        @(negedge clk); pkt_rdy_i = 0;
        chk(empty_o == 1'b0, "R3 empty falls on accept", empty_o, 0);
    endtask

    task automatic fire(input bit at_sav, input logic [11:0] room, input bit vbl);
        @(negedge clk);
        vid_i = HOLD; vblank_i = vbl;
        if (at_sav) begin sav_xyz_i = 1; v_room_i = room; end
        else        begin eav_xyz_i = 1; h_room_i = room; end
        @(negedge clk);
        eav_xyz_i = 0; sav_xyz_i = 0;
    endtask

    task automatic send(input bit at_sav, input logic [11:0] room, input bit vbl, input string tag);
        fire(at_sav, room, vbl);
        for (int k = 0; k < exp_len; k++) begin
            @(negedge clk);
            if (k == 0)                chk(vid_o == exp_w[k], tag, vid_o, exp_w[k]);
            else if (k < 6)            chk(vid_o == exp_w[k], "R1 R4 header word", vid_o, exp_w[k]);
            else if (k == exp_len - 1) chk(vid_o == exp_w[k], "R5 checksum", vid_o, exp_w[k]);
            else                       chk(vid_o == exp_w[k], "R2 R6 user word", vid_o, exp_w[k]);
        end
        chk(empty_o == 1'b1, "R3 empty with checksum", empty_o, 1);
        @(negedge clk);
        chk(vid_o == HOLD, "R11 pass after packet", vid_o, HOLD);
    endtask

    task automatic no_insert(input bit at_sav, input logic [11:0] room, input bit vbl, input string tag);
        fire(at_sav, room, vbl);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(vid_o == HOLD && empty_o == 1'b0, tag, {vid_o, 1'b0, empty_o}, {HOLD, 2'b00});
        end
    endtask

    task automatic t_reset();
        chk(empty_o == 1'b1, "R3 reset empty", empty_o, 1);
        chk(vid_o == 10'h000, "R11 reset output", vid_o, 0);
    endtask

    task automatic t_pass();
        logic [9:0] v [3] = '{10'h2A7, 10'h001, 10'h3FE};
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); vid_i = v[k];
            @(negedge clk);
            chk(vid_o == v[k], "R11 pass-through", vid_o, v[k]);
        end
    endtask

    task automatic t_hanc_exact();
        load_ram();
        load_hdr(8'h61, 8'h02, 8'd4);
        build(8'h61, 8'h02, 8'd4, 0);
        arm(1, 0, 0);
        send(0, 12'd11, 0, "R7 exact fit start");
    endtask

    task automatic t_defer();
        load_hdr(8'hA3, 8'h7F, 8'd5);
        build(8'hA3, 8'h7F, 8'd5, 1);
        arm(1, 0, 1);
        no_insert(0, 12'd11, 0, "R8 one word too long");
        send(0, 12'd12, 0, "R7 R8 next line");
    endtask

    task automatic t_vanc_locked();
        load_hdr(8'h45, 8'h10, 8'd3);
        build(8'h45, 8'h10, 8'd3, 0);
        arm(0, 1, 0);
        load_hdr(8'hFF, 8'hEE, 8'd32);      // R10 must be ignored
        @(negedge clk); udw_addr_i = 8'd0; data_i = ~ram_m[0]; ld_udw_i = 1;
        @(negedge clk); ld_udw_i = 0;
        no_insert(0, 12'd200, 0, "R12 horizontal not selected");
        no_insert(1, 12'd200, 0, "R9 marker outside vertical blanking");
        send(1, 12'd10, 1, "R9 R10 vertical insert");
    endtask

    task automatic t_dc_zero();
        load_hdr(8'h01, 8'h00, 8'd0);
        build(8'h01, 8'h00, 8'd0, 0);
        arm(1, 1, 0);
        no_insert(0, 12'd6, 0, "R8 zero count needs seven");
        send(0, 12'd7, 0, "R7 zero count packet");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_pass();
        t_hanc_exact();
        t_defer();
        t_vanc_locked();
        t_dc_zero();
        if (!over) begin
            over = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!over) begin
            over = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule